// File: doc/BRIEF.md
# Cascadable 8-to-3 Priority Encoder

This block is a purely combinational priority encoder. It takes eight request lines and returns a 3-bit code naming the highest-numbered request that is active. All request lines and all outputs are active-low. An active-low enable input turns the encoder on. When it is off, every output is held inactive.

Two extra status outputs let encoders be chained. The idle flag goes low when the encoder is enabled and sees no request. The grant strobe goes low when the encoder is enabled and at least one request is active. To form a 16-to-4 encoder, the idle flag of the upper cell drives the enable of the lower cell. The upper cell's grant strobe becomes the most significant code bit. The two 3-bit codes are combined with an AND, since they are active-low.

Top module: `prienc_cascade_cell`

## Requirements
- R1: While `en_n` is 1 (disabled), `code_n` is 3'b111, `idle_n` is 1 and `grant_n` is 1, whatever the request lines carry.
- R2: While `en_n` is 0 and all bits of `req_n` are 1 (no request), `idle_n` is 0, `grant_n` is 1 and `code_n` is 3'b111.
- R3: While `en_n` is 0 and at least one bit of `req_n` is 0, `grant_n` is 0 and `idle_n` is 1.
- R4: When enabled with at least one request, `code_n` is the bitwise complement of the index of the highest-numbered request whose bit is 0. Request 7 has the highest priority and request 0 the lowest. For example, request 5 winning gives `code_n` = 3'b010.
- R5: Requests below the winning one are ignored. Changing any `req_n` bit below the highest active index leaves `code_n`, `idle_n` and `grant_n` unchanged.
- R6: Two cells chained as follows form a 16-to-4 encoder with an active-low 4-bit code equal to the complement of the highest active index among 16 requests. The upper cell takes requests 15..8 and the external enable. The lower cell takes requests 7..0 and the upper cell's `idle_n` as its enable. The code MSB is the upper cell's `grant_n`, and the lower three bits are the AND of both cells' `code_n`.
- R7: `idle_n` and `grant_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | 8 (NUM_REQ) | Request lines, active-low; bit i is request i |
| en_n | input | 1 | Enable, active-low |
| code_n | output | 3 (CODE_W) | Complement of the winning request index; 111 when no winner |
| idle_n | output | 1 | Low when enabled and no request is active |
| grant_n | output | 1 | Low when enabled and at least one request is active |

## Verification
The assertions are immediate checks on settled combinational values, so they assume that every input is a defined 0 or 1 and never X or Z. The bench meets this by driving every request and enable bit to a known level from time zero. Inputs change only just after a rising clock edge, and values are sampled at the falling edge. The random stimulus draws full 8-bit and 16-bit request words and a biased enable bit, so every input stays within the two defined levels.

// File: rtl/prienc_pkg.sv
package prienc_pkg;

    // Operating condition of one encoder cell, decided from enable and requests
    typedef enum logic [1:0] {
        CELL_OFF   = 2'd0,  // enable inactive
        CELL_IDLE  = 2'd1,  // enabled, nothing requested
        CELL_GRANT = 2'd2   // enabled, a request won
    } cell_mode_e;

endpackage

// File: rtl/prienc_scan.sv
module prienc_scan #(
    parameter int NUM_REQ = 8,
    parameter int CODE_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req_n,
    output logic               any_hit,
    output logic [CODE_W-1:0]  win_idx
);

    logic [NUM_REQ-1:0] active;

    // Convert each active-low line to an active-high flag
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_line
        assign active[g] = ~req_n[g];
    end

    assign any_hit = |active;

    // Ascending scan: a later (higher) index overrides any lower one
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (active[i]) begin
                win_idx = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/prienc_outstage.sv
module prienc_outstage
    import prienc_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              en_n,
    input  logic              any_hit,
    input  logic [CODE_W-1:0] win_idx,
    output logic [CODE_W-1:0] code_n,
    output logic              idle_n,
    output logic              grant_n
);

    cell_mode_e mode;

    // Mode decision
    always_comb begin
        if (en_n) begin
            mode = CELL_OFF;
        end else if (any_hit) begin
            mode = CELL_GRANT;
        end else begin
            mode = CELL_IDLE;
        end
    end

    // Output drive per mode
    always_comb begin
        code_n  = '1;
        idle_n  = 1'b1;
        grant_n = 1'b1;
        unique case (mode)
            CELL_OFF: begin
                code_n  = '1;
            end
            CELL_IDLE: begin
                idle_n  = 1'b0;
            end
            CELL_GRANT: begin
                grant_n = 1'b0;
                code_n  = ~win_idx;
            end
            default: begin
                code_n  = '1;
            end
        endcase
    end

endmodule

// File: rtl/prienc_cascade_cell.sv
module prienc_cascade_cell #(
    parameter int NUM_REQ = 8,
    localparam int CODE_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req_n,
    input  logic               en_n,
    output logic [CODE_W-1:0]  code_n,
    output logic               idle_n,
    output logic               grant_n
);

    logic              any_hit;
    logic [CODE_W-1:0] win_idx;

    prienc_scan #(
        .NUM_REQ (NUM_REQ),
        .CODE_W  (CODE_W)
    ) u_scan (
        .req_n   (req_n),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    prienc_outstage #(
        .CODE_W  (CODE_W)
    ) u_out (
        .en_n    (en_n),
        .any_hit (any_hit),
        .win_idx (win_idx),
        .code_n  (code_n),
        .idle_n  (idle_n),
        .grant_n (grant_n)
    );

endmodule

// File: rtl/prienc_cascade_cell_chk.sv
module prienc_cascade_cell_chk #(
    parameter int NUM_REQ = 8,
    parameter int CODE_W  = 3
) (
    input logic [NUM_REQ-1:0] req_n,
    input logic               en_n,
    input logic [CODE_W-1:0]  code_n,
    input logic               idle_n,
    input logic               grant_n
);

    logic [CODE_W-1:0] named_idx;
    logic              named_active;
    logic              above_clear;

    assign named_idx = ~code_n;

    always_comb begin
        named_active = 1'b0;
        above_clear  = 1'b1;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (CODE_W'(i) == named_idx) begin
                named_active = ~req_n[i];
            end
            if (i > int'(named_idx) && !req_n[i]) begin
                above_clear = 1'b0;
            end
        end
    end

    always_comb begin
        if (en_n) begin
            p_disabled_quiet_r1: assert (code_n == '1 && idle_n && grant_n)
                else $error("R1 disabled cell drives an active output");
        end
        if (!en_n && (&req_n)) begin
            p_idle_flag_r2: assert (!idle_n && grant_n && code_n == '1)
                else $error("R2 idle flag wrong");
        end
        if (!en_n && !(&req_n)) begin
            p_strobe_r3: assert (!grant_n && idle_n)
                else $error("R3 grant strobe wrong");
        end
        if (!grant_n) begin
            p_winner_active_r4: assert (named_active)
                else $error("R4 named request not active");
            p_higher_clear_r5: assert (above_clear)
                else $error("R5 higher request was passed over");
        end
        p_flags_exclusive_r7: assert (idle_n || grant_n)
            else $error("R7 idle and grant both asserted");
    end

endmodule

bind prienc_cascade_cell prienc_cascade_cell_chk #(
    .NUM_REQ (NUM_REQ),
    .CODE_W  (CODE_W)
) u_chk (
    .req_n   (req_n),
    .en_n    (en_n),
    .code_n  (code_n),
    .idle_n  (idle_n),
    .grant_n (grant_n)
);

// File: tb/test_prienc_cascade_cell.sv
module test_prienc_cascade_cell;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // single cell under test
    logic [7:0] req_n    = 8'hFF;
    logic       en_drv_n = 1'b1;
    logic       en_n;
    logic [2:0] code_n;
    logic       idle_n;
    logic       grant_n;

    assign en_n = rst_n ? en_drv_n : 1'b1;

    prienc_cascade_cell i_prienc_cascade_cell (
        .req_n   (req_n),
        .en_n    (en_n),
        .code_n  (code_n),
        .idle_n  (idle_n),
        .grant_n (grant_n)
    );

    // 16-to-4 chain (R6)
    logic [15:0] req16_n   = 16'hFFFF;
    logic        en16_n    = 1'b1;
    logic [2:0]  hi_code_n, lo_code_n;
    logic        hi_idle_n, lo_idle_n, hi_grant_n, lo_grant_n;
    logic [3:0]  code16_n;
    logic        grant16_n;

    prienc_cascade_cell i_prienc_cascade_cell_hi (
        .req_n   (req16_n[15:8]),
        .en_n    (en16_n),
        .code_n  (hi_code_n),
        .idle_n  (hi_idle_n),
        .grant_n (hi_grant_n)
    );

    prienc_cascade_cell i_prienc_cascade_cell_lo (
        .req_n   (req16_n[7:0]),
        .en_n    (hi_idle_n),
        .code_n  (lo_code_n),
        .idle_n  (lo_idle_n),
        .grant_n (lo_grant_n)
    );

    assign code16_n  = {hi_grant_n, hi_code_n & lo_code_n};
    assign grant16_n = hi_grant_n & lo_grant_n;

    // expected {code_n, idle_n, grant_n} for one cell
    function automatic logic [4:0] exp8(input logic [7:0] r, input logic e);
        logic [2:0] idx;
        logic       hit;
        idx = 3'd0;
        hit = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (!hit && !r[i]) begin
                idx = 3'(i);
                hit = 1'b1;
            end
        end
        if (e)        return 5'b111_1_1;
        else if (!hit) return 5'b111_0_1;
        else           return {~idx, 1'b1, 1'b0};
    endfunction

    // expected {code16_n, grant16_n}
    function automatic logic [4:0] exp16(input logic [15:0] r, input logic e);
        logic [3:0] idx;
        logic       hit;
        idx = 4'd0;
        hit = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (!hit && !r[i]) begin
                idx = 4'(i);
                hit = 1'b1;
            end
        end
        if (e || !hit) return 5'b1111_1;
        else           return {~idx, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply8(input logic [7:0] r, input logic e, input string tag);
        @(posedge clk);
        req_n    = r;
        en_drv_n = e;
        @(negedge clk);
        chk(tag, {code_n, idle_n, grant_n}, exp8(r, e));
    endtask

    task automatic apply16(input logic [15:0] r, input logic e);
        @(posedge clk);
        req16_n = r;
        en16_n  = e;
        @(negedge clk);
        chk("R6 cascade", {code16_n, grant16_n}, exp16(r, e));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [4:0]  ref_out;
        logic [7:0]  r8;
        logic [15:0] r16;
        void'($urandom(32'd1234));

        // reset: enable forced off, outputs quiet (R1)
        req_n = 8'h00;
        en_drv_n = 1'b0;
        @(negedge clk);
        chk("R1 reset", {code_n, idle_n, grant_n}, 5'b111_1_1);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R1: disabled with assorted requests
        apply8(8'h00, 1'b1, "R1 disabled all");
        apply8(8'h7F, 1'b1, "R1 disabled top");
        apply8(8'hFE, 1'b1, "R1 disabled low");
        // R2: enabled, nothing requested
        apply8(8'hFF, 1'b0, "R2 idle");
        // R3, R4: each single request
        for (int i = 0; i < 8; i++) begin
            apply8(~(8'h01 << i), 1'b0, "R3 R4 single");
        end
        // R4: all active gives 000
        apply8(8'h00, 1'b0, "R4 all active");
        // R5: fixed winner 5, lower bits varied
        apply8(8'hDF, 1'b0, "R5 base");
        ref_out = {code_n, idle_n, grant_n};
        for (int k = 0; k < 32; k++) begin
            @(posedge clk);
            req_n = {3'b110, 5'(k)};
            @(negedge clk);
            chk("R5 lower ignored", {code_n, idle_n, grant_n}, ref_out);
        end
        // R7 via random sweep (idle/grant pair compared)
        for (int n = 0; n < 400; n++) begin
            r8 = 8'($urandom);
            if (n % 3 == 0) r8 = r8 | 8'($urandom);  // sparse requests
            apply8(r8, ($urandom % 5) == 0, "R7 R4 random");
        end

        // R6 cascade directed
        apply16(16'hFFFF, 1'b0);
        apply16(16'hFFFF, 1'b1);
        apply16(16'h0000, 1'b1);
        apply16(16'hFFFE, 1'b0);
        apply16(16'hFF7F, 1'b0);
        apply16(16'hFEFF, 1'b0);
        apply16(16'h7FFF, 1'b0);
        apply16(16'hFE00, 1'b0);
        for (int n = 0; n < 300; n++) begin
            r16 = 16'($urandom) | 16'($urandom);
            apply16(r16, ($urandom % 6) == 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule